// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Block

This block is the software-facing register file of a 16550-compatible serial port. A processor reaches eight byte-wide registers through a simple request/response bus. Received bytes arrive from a serial front end as single-cycle strobes and wait in a 64-entry receive queue. Bytes that software writes to the data register leave through a valid/ready byte output. Bit-level shifting, baud timing and modem-line sensing sit outside the block.

The register index is taken from the bus address after a right shift by `REG_SHIFT`, keeping three bits. Only accesses of exactly `IO_WIDTH` bytes take effect. A divisor-latch select bit in the line control register re-maps indices 0 and 1 onto the two divisor bytes. A loopback bit in the modem control register steers transmitted bytes into the receive queue. The interrupt output reports two conditions: received data waiting, and transmitter empty. An identification register tells software which of them is active.

Top module: `uart_reg_block`

## Requirements
- R1: After reset, reads return: index 0 = 0x00, index 1 = 0x00, index 2 = 0xC1, index 3 = 0x00, index 4 = 0x08, index 5 = 0x60, index 6 = 0xB0, index 7 = 0x00. The divisor low byte is 0x0C and the divisor high byte is 0x00. `irq` is low.
- R2: A request whose `bus_len` differs from `IO_WIDTH` changes no state. Its response has `rsp_err`=1 and `rsp_rdata`=0. Every request gets `rsp_valid` one cycle later.
- R3: The register index is `(bus_addr >> REG_SHIFT) & 7`, so with `REG_SHIFT`=0 the addresses 0x07, 0x0F and 0x17 all reach the scratch register.
- R4: While line-control bit 7 is 1, index 0 reads and writes the divisor low byte and index 1 the divisor high byte. The interrupt-enable register and the receive queue are not touched.
- R5: Writes to the interrupt-enable register (index 1, bit 7 of line control clear) keep only bits 3:0. Writes to index 5 (line status) and index 6 (modem status) are ignored.
- R6: The identification value is 0x04 when enable bit 0 is set and data is ready, plus 0x02 when enable bit 1 is set and the transmitter is empty (the two codes OR together). It is 0x01 when neither holds. Reads of index 2 return it ORed with 0xC0. `irq` is high exactly when the value is not 0x01.
- R7: A strobed receive byte enters the queue only when FIFO-control bit 0 is 1, loopback (modem-control bit 4) is 0 and fewer than 64 bytes are queued; otherwise it is dropped.
- R8: A read of index 0 (bit 7 of line control clear) returns and removes the oldest queued byte. On an empty queue it returns 0. Line-status bit 0 (data ready) is 1 exactly while the queue is non-empty.
- R9: A `rx_break` pulse sets line-status bit 4. The next read of index 0 on a non-empty queue returns 0, clears bit 4 and leaves the queue unchanged.
- R10: Writing index 0 with loopback off presents the byte on `tx_data` with `tx_valid`=1. The byte is held until a cycle with `tx_ready`=1. Line-status bits 6 and 5 stay 1.
- R11: With loopback on, a write to index 0 pushes the byte into the receive queue (if not full), does not raise `tx_valid`, and external receive strobes are dropped.
- R12: Writing index 2 with bit 1 set empties the receive queue. Bits 1 and 2 are not retained, while bit 0 is kept.
- R13: A receive strobe and a read of index 0 in the same cycle both take effect: the head byte is returned and the new byte is appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_len | input | LEN_W | Access size in bytes |
| bus_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response, one cycle after a request |
| rsp_err | output | 1 | Request rejected for its size |
| rsp_rdata | output | 8 | Read byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break condition seen by the line receiver |
| tx_valid | output | 1 | Transmit byte waiting |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit byte taken |
| irq | output | 1 | Interrupt request |

## Verification
The functions that collide are the serial receiver appending to the queue and software draining it through index 0. Both move the queue count, in opposite directions, in the same cycle. The bench raises `rx_valid` in the very cycle that a read of index 0 is sampled on a queue holding two bytes. It then judges the outcome by the returned head byte and by draining the queue: the two older bytes and then the new one must appear in order, followed by an empty read. A second overlap, a flush command meeting a queued byte, is judged by the empty read that follows it.

// File: rtl/urb_pkg.sv
package urb_pkg;
  typedef enum logic [2:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IID   = 3'd2,
    OFS_LCTL  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SCR   = 3'd7
  } urb_ofs_e;

  localparam int LCTL_DIVSEL  = 7;
  localparam int MCTL_LOOP    = 4;
  localparam int FCTL_RXEN    = 0;
  localparam int FCTL_RXFLUSH = 1;

  localparam logic [7:0] IID_NONE  = 8'h01;
  localparam logic [7:0] IID_TYPE  = 8'hC0;
  localparam logic [7:0] RST_DIVL  = 8'h0C;
  localparam logic [7:0] RST_MCTL  = 8'h08;
  localparam logic [7:0] MSTAT_VAL = 8'hB0;
  localparam logic [7:0] FCTL_KEEP = 8'hF9;
endpackage

// File: rtl/urb_rxq.sv
module urb_rxq #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem[rptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok)  rptr <= nxt(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)) else $error("queue count above depth");

  p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> full) else $error("full queue lost its state");

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty) else $error("pop of empty queue moved count");

  p_both_r13: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty && !full && !flush) |=> $stable(count)) else $error("push+pop changed count");
endmodule

// File: rtl/urb_intid.sv
module urb_intid
  import urb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd_en,
  input  logic       txe_en,
  input  logic       data_rdy,
  input  logic       tx_empty,
  output logic [7:0] iid,
  output logic       irq
);
  logic [7:0] code;

  assign code = {5'b0, rxd_en && data_rdy, txe_en && tx_empty, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      iid <= IID_NONE;
      irq <= 1'b0;
    end else begin
      iid <= (code == 8'h00) ? IID_NONE : code;
      irq <= (code != 8'h00);
    end
  end

  p_rxd_raises_r6: assert property (@(posedge clk) disable iff (rst)
    (rxd_en && data_rdy) |=> (irq && iid[2])) else $error("rx data interrupt missing");

  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!(rxd_en && data_rdy) && !(txe_en && tx_empty)) |=> (!irq && iid == IID_NONE))
    else $error("interrupt without cause");
endmodule

// File: rtl/uart_reg_block.sv
module uart_reg_block
  import urb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_SHIFT = 0,
  parameter int IO_WIDTH  = 1,
  parameter int LEN_W     = 3,
  parameter int RXQ_DEPTH = 64,
  localparam int QCW      = $clog2(RXQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LEN_W-1:0]  bus_len,
  input  logic [7:0]        bus_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [7:0]        rsp_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_break,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              irq
);
  logic [7:0] ien_q, lctl_q, mctl_q, fctl_q, scr_q, divl_q, divh_q;
  logic       brk_q;
  logic       acc, wr, rd, divsel, loop;
  urb_ofs_e   ofs;
  logic       wr_thr, rd_rbr, q_push, q_pop, q_flush;
  logic [7:0] q_push_data, q_head, iid, lstat, rmux;
  logic [QCW-1:0] q_count;
  logic       q_empty, q_full;

  assign acc    = bus_valid && (bus_len == LEN_W'(IO_WIDTH));
  assign wr     = acc && bus_write;
  assign rd     = acc && !bus_write;
  assign ofs    = urb_ofs_e'(bus_addr[REG_SHIFT +: 3]);
  assign divsel = lctl_q[LCTL_DIVSEL];
  assign loop   = mctl_q[MCTL_LOOP];

  assign wr_thr  = wr && (ofs == OFS_DATA) && !divsel;
  assign rd_rbr  = rd && (ofs == OFS_DATA) && !divsel;
  assign q_flush = wr && (ofs == OFS_IID) && bus_wdata[FCTL_RXFLUSH];
  assign q_push  = (wr_thr && loop) || (rx_valid && fctl_q[FCTL_RXEN] && !loop);
  assign q_push_data = (wr_thr && loop) ? bus_wdata : rx_data;
  assign q_pop   = rd_rbr && !brk_q;

  urb_rxq #(.DEPTH(RXQ_DEPTH), .DW(8)) u_rxq (
    .clk, .rst,
    .flush(q_flush), .push(q_push), .push_data(q_push_data), .pop(q_pop),
    .head(q_head), .count(q_count), .empty(q_empty), .full(q_full)
  );

  urb_intid u_intid (
    .clk, .rst,
    .rxd_en(ien_q[0]), .txe_en(ien_q[1]),
    .data_rdy(!q_empty), .tx_empty(1'b1),
    .iid(iid), .irq(irq)
  );

  // transmit hand-off is immediate, so both empty flags read as 1
  assign lstat = {1'b0, 1'b1, 1'b1, brk_q, 3'b000, !q_empty};

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= 8'h00;
      lctl_q <= 8'h00;
      mctl_q <= RST_MCTL;
      fctl_q <= 8'h00;
      scr_q  <= 8'h00;
      divl_q <= RST_DIVL;
      divh_q <= 8'h00;
    end else if (wr) begin
      case (ofs)
        OFS_DATA: if (divsel) divl_q <= bus_wdata;
        OFS_IEN:  if (divsel) divh_q <= bus_wdata;
                  else        ien_q  <= {4'b0, bus_wdata[3:0]};
        OFS_IID:  fctl_q <= bus_wdata & FCTL_KEEP;
        OFS_LCTL: lctl_q <= bus_wdata;
        OFS_MCTL: mctl_q <= bus_wdata;
        OFS_SCR:  scr_q  <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_q <= 1'b0;
    end else if (rx_break) begin
      brk_q <= 1'b1;
    end else if (rd_rbr && !q_empty) begin
      brk_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
    end else if (wr_thr && !loop) begin
      tx_valid <= 1'b1;
      tx_data  <= bus_wdata;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  always_comb begin
    case (ofs)
      OFS_DATA:  rmux = divsel ? divl_q : ((q_empty || brk_q) ? 8'h00 : q_head);
      OFS_IEN:   rmux = divsel ? divh_q : ien_q;
      OFS_IID:   rmux = iid | IID_TYPE;
      OFS_LCTL:  rmux = lctl_q;
      OFS_MCTL:  rmux = mctl_q;
      OFS_LSTAT: rmux = lstat;
      OFS_MSTAT: rmux = MSTAT_VAL;
      default:   rmux = scr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= 8'h00;
    end else begin
      rsp_valid <= bus_valid;
      rsp_err   <= bus_valid && !acc;
      rsp_rdata <= rd ? rmux : 8'h00;
    end
  end

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> rsp_valid) else $error("missing response");

  p_bad_width_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_len != LEN_W'(IO_WIDTH)) |=> (rsp_err && rsp_rdata == 8'h00))
    else $error("wrong-size access not flagged");

  p_tx_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !wr_thr) |=> (tx_valid && $stable(tx_data)))
    else $error("transmit byte dropped before ready");

  p_loop_no_tx_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_thr && loop && !tx_valid) |=> !tx_valid) else $error("loopback byte left on tx");
endmodule

// File: tb/sim_uart_reg_block.sv
module sim_uart_reg_block;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [2:0] bus_len = 3'd1;
  logic [7:0] bus_wdata = '0;
  logic       rsp_valid, rsp_err;
  logic [7:0] rsp_rdata;
  logic       rx_valid = 1'b0, rx_break = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_valid, irq;
  logic [7:0] tx_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  uart_reg_block u0 (
    .clk, .rst, .bus_valid, .bus_write, .bus_addr, .bus_len, .bus_wdata,
    .rsp_valid, .rsp_err, .rsp_rdata, .rx_valid, .rx_data, .rx_break,
    .tx_valid, .tx_data, .tx_ready, .irq
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tx_ready = 1'b0;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [2:0] len,
                     input logic [7:0] d, output logic [7:0] q, output logic e);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_len = len; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    q = rsp_rdata; e = rsp_err;
    if (rsp_valid !== 1'b1) chk("R2 rsp_valid", rsp_valid, 1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] q; logic e;
    bus(1'b1, a, 3'd1, d, q, e);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] q);
    logic e;
    bus(1'b0, a, 3'd1, 8'h00, q, e);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] q;
    rd(a, q);
    chk(req, q, exp);
  endtask

  task automatic rx(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset_values();
    do_reset();
    chk("R1 irq", irq, 0);
    rd_chk("R1 idx0", 8'd0, 8'h00);
    rd_chk("R1 idx1", 8'd1, 8'h00);
    rd_chk("R1 idx2", 8'd2, 8'hC1);
    rd_chk("R1 idx3", 8'd3, 8'h00);
    rd_chk("R1 idx4", 8'd4, 8'h08);
    rd_chk("R1 idx5", 8'd5, 8'h60);
    rd_chk("R1 idx6", 8'd6, 8'hB0);
    rd_chk("R1 idx7", 8'd7, 8'h00);
    wr(8'd3, 8'h80);
    rd_chk("R1 divisor low", 8'd0, 8'h0C);
    rd_chk("R1 divisor high", 8'd1, 8'h00);
  endtask

  task automatic t_width_alias();
    logic [7:0] q; logic e;
    do_reset();
    bus(1'b1, 8'd7, 3'd2, 8'hAA, q, e);
    chk("R2 err on write", e, 1);
    bus(1'b0, 8'd7, 3'd4, 8'h00, q, e);
    chk("R2 err on read", e, 1);
    chk("R2 rdata zero", q, 0);
    rd_chk("R2 scratch untouched", 8'd7, 8'h00);
    wr(8'h0F, 8'h3C);
    rd_chk("R3 alias 0x07", 8'h07, 8'h3C);
    wr(8'h17, 8'h5D);
    rd_chk("R3 alias 0x0F", 8'h0F, 8'h5D);
  endtask

  task automatic t_divisor_masks();
    do_reset();
    wr(8'd1, 8'hFF);
    rd_chk("R5 ien low nibble", 8'd1, 8'h0F);
    wr(8'd1, 8'h00);
    wr(8'd3, 8'h80);
    wr(8'd0, 8'h34);
    wr(8'd1, 8'h12);
    rd_chk("R4 div low", 8'd0, 8'h34);
    rd_chk("R4 div high", 8'd1, 8'h12);
    wr(8'd3, 8'h03);
    rd_chk("R4 ien untouched", 8'd1, 8'h00);
    rd_chk("R4 lctl", 8'd3, 8'h03);
    chk("R4 no tx", tx_valid, 0);
    wr(8'd5, 8'h00);
    wr(8'd6, 8'h00);
    rd_chk("R5 lstat write ignored", 8'd5, 8'h60);
    rd_chk("R5 mstat write ignored", 8'd6, 8'hB0);
  endtask

  task automatic t_irq();
    do_reset();
    wr(8'd2, 8'h01);
    wr(8'd1, 8'h01);
    idle(2);
    chk("R6 no irq on empty", irq, 0);
    rx(8'h21);
    idle(2);
    chk("R6 irq rx", irq, 1);
    rd_chk("R6 iid rx", 8'd2, 8'hC4);
    wr(8'd1, 8'h03);
    idle(2);
    rd_chk("R6 iid both", 8'd2, 8'hC6);
    wr(8'd1, 8'h02);
    idle(2);
    rd_chk("R6 iid tx", 8'd2, 8'hC2);
    wr(8'd1, 8'h00);
    idle(2);
    chk("R6 irq off", irq, 0);
    rd_chk("R6 iid none", 8'd2, 8'hC1);
  endtask

  task automatic t_rx_gate_fill();
    do_reset();
    rx(8'h11);
    rd_chk("R7 dropped when disabled", 8'd5, 8'h60);
    wr(8'd2, 8'h01);
    for (int i = 0; i < 65; i++) rx(8'(i + 1));
    rd_chk("R8 data ready", 8'd5, 8'h61);
    for (int i = 0; i < 64; i++) rd_chk("R7 queue order", 8'd0, 8'(i + 1));
    rd_chk("R7 65th dropped", 8'd0, 8'h00);
    rd_chk("R8 ready clear", 8'd5, 8'h60);
  endtask

  task automatic t_break();
    do_reset();
    wr(8'd2, 8'h01);
    rx(8'h55);
    @(negedge clk); rx_break = 1'b1; @(negedge clk); rx_break = 1'b0;
    rd_chk("R9 break flagged", 8'd5, 8'h71);
    rd_chk("R9 break read zero", 8'd0, 8'h00);
    rd_chk("R9 break cleared", 8'd5, 8'h61);
    rd_chk("R9 byte kept", 8'd0, 8'h55);
    rd_chk("R8 empty", 8'd5, 8'h60);
  endtask

  task automatic t_tx();
    do_reset();
    wr(8'd0, 8'h41);
    chk("R10 tx_valid", tx_valid, 1);
    chk("R10 tx_data", tx_data, 8'h41);
    idle(3);
    chk("R10 held", tx_valid, 1);
    rd_chk("R10 lstat", 8'd5, 8'h60);
    tx_ready = 1'b1;
    idle(1);
    chk("R10 taken", tx_valid, 0);
    tx_ready = 1'b0;
  endtask

  task automatic t_loop();
    do_reset();
    wr(8'd2, 8'h01);
    wr(8'd4, 8'h18);
    wr(8'd0, 8'h5A);
    chk("R11 no tx", tx_valid, 0);
    rx(8'h77);
    rd_chk("R11 ready set", 8'd5, 8'h61);
    rd_chk("R11 looped byte", 8'd0, 8'h5A);
    rd_chk("R11 rx strobe dropped", 8'd0, 8'h00);
  endtask

  task automatic t_flush();
    do_reset();
    wr(8'd2, 8'h01);
    rx(8'h01); rx(8'h02); rx(8'h03);
    wr(8'd2, 8'h07);
    rd_chk("R12 flushed", 8'd5, 8'h60);
    rd_chk("R12 read empty", 8'd0, 8'h00);
    rx(8'h99);
    rd_chk("R12 enable kept", 8'd0, 8'h99);
  endtask

  task automatic t_concurrent();
    logic [7:0] q;
    do_reset();
    wr(8'd2, 8'h01);
    rx(8'hA1); rx(8'hB2);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'd0; bus_len = 3'd1;
    rx_valid = 1'b1; rx_data = 8'hC3;
    @(negedge clk);
    bus_valid = 1'b0; rx_valid = 1'b0;
    chk("R13 head returned", rsp_rdata, 8'hA1);
    rd(8'd0, q); chk("R13 second", q, 8'hB2);
    rd(8'd0, q); chk("R13 appended", q, 8'hC3);
    rd(8'd0, q); chk("R13 then empty", q, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_values();
    t_width_alias();
    t_divisor_masks();
    t_irq();
    t_rx_gate_fill();
    t_break();
    t_tx();
    t_loop();
    t_flush();
    t_concurrent();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule